// File: doc/BRIEF.md
# Serial Port with Multiprocessor Address Filtering

This block is a second asynchronous serial port for an 8-bit controller. Software reaches it through a small register bus: a 3-bit address, write data, read data and separate write and read strobes. One register address is shared by two buffers. A write to it starts a transmit frame, and a read returns the last accepted receive byte. Two further registers hold the mode, the flags and the clocking choices. Two more hold the slave address and its mask. The port drives a transmit line, watches a receive line, and raises one interrupt request.

The bit clock comes from two overflow pulse inputs, one from each of two timers. The receiver and the transmitter each pick their own source. Unless the double-rate bit is set, the chosen pulse is halved, and each serial bit lasts 16 of the resulting oversample ticks. The receiver takes three votes near the middle of every bit. In 9-bit mode with multiprocessor filtering on, it keeps only address frames whose byte matches the masked slave address or the broadcast address. It can also flag a stop bit that samples low.

The register bus has no back-pressure. A write always completes in its cycle. A read returns its data one cycle after the strobe. Flow control of the serial data is left to software, which watches the two flags.

Top module: `u2_port`

## Requirements
- R1: After reset, the control register (address 1) and the auxiliary register (address 2) read 0x00, the transmit line is high and the interrupt output is low.
- R2: A write to address 0 while the transmitter is idle sends one frame: a low start bit, the eight data bits least significant first, then in 9-bit mode (control bit 7) the value of control bit 3, then a high stop bit. Each bit lasts 16 oversample ticks. A write to address 0 during a frame is ignored.
- R3: While receive enable (control bit 4) is 1, a start bit is taken only if at least two of its three mid-bit votes are low. Otherwise the receiver goes back to searching. A frame received with filtering off sets control bit 0 and makes its byte readable at address 0. Control bit 2 takes the ninth bit in 9-bit mode and is 0 in 8-bit mode. With receive enable 0, nothing is received.
- R4: Control bit 1 (the transmit flag) is set when the stop bit of a transmit frame ends.
- R5: Auxiliary bit 1 selects the receive overflow source and bit 2 selects the transmit source (0 selects the first timer input, 1 the second). Auxiliary bit 0 doubles the rate. Without it, every second overflow makes an oversample tick. With it, every overflow does.
- R6: In 9-bit mode with multiprocessor filtering on (control bit 5), a frame whose ninth bit is 0 is dropped and control bit 0 is not set.
- R7: A frame with a ninth bit of 1 is accepted when its byte equals the slave address (address 3) in every bit where the mask (address 4) is 1. Mask bits of 0 are ignored.
- R8: Such a frame is also accepted when its byte is 1 in every bit where the mask is 1 (the broadcast address). Any other address frame is dropped.
- R9: With framing check on (auxiliary bit 3), a received stop bit that votes low sets a flag. Control bit 7 then reads that flag. Writing 0 to control bit 7 clears it, and writing 1 leaves it unchanged. Auxiliary bit 5 always reads and writes the 9-bit mode bit.
- R10: The interrupt output is high exactly when auxiliary bit 4 is 1 and control bit 0 or control bit 1 is 1.
- R11: A read strobe returns the addressed register on the read data port from the next cycle on. Addresses 5 to 7 read 0.
- R12: A write to the control register sets the flag bits 0 to 2, so software clears a flag by writing 0 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 3 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_wr | input | 1 | Write strobe |
| sfr_rd | input | 1 | Read strobe |
| sfr_rdata | output | 8 | Registered read data |
| tmr1_ovf | input | 1 | First timer overflow pulse |
| tmr2_ovf | input | 1 | Second timer overflow pulse |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| irq | output | 1 | Interrupt request |

## Verification
The transmit line is looped back to the receive line. Bytes are sent in 8-bit mode, in 9-bit mode with both ninth-bit values, and under four combinations of source and rate. The measured start-bit width separates a wrong source from a missing halving. Address frames are sent against full, upper-nibble, lower-nibble and empty masks, with bytes chosen to hit only the given address, only the broadcast address, or neither, so that the two match rules are told apart. A stop bit forced low, with the framing check off and then on, shows that the flag and the shared control bit react only when the check is enabled. A short low glitch and a frame sent with receive enable off both show that nothing is received.

// File: rtl/u2_pkg.sv
package u2_pkg;
  localparam int DW     = 8;
  localparam int SFR_AW = 3;

  localparam logic [SFR_AW-1:0] RA_DATA  = 3'd0;
  localparam logic [SFR_AW-1:0] RA_CTRL  = 3'd1;
  localparam logic [SFR_AW-1:0] RA_AUX   = 3'd2;
  localparam logic [SFR_AW-1:0] RA_SADDR = 3'd3;
  localparam logic [SFR_AW-1:0] RA_SMASK = 3'd4;
endpackage

// File: rtl/u2_baud.sv
module u2_baud (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_a,
  input  logic ovf_b,
  input  logic sel,
  input  logic dbl,
  output logic os_tick
);
  logic ovf;
  logic half;

  assign ovf = sel ? ovf_b : ovf_a;

  always_ff @(posedge clk) begin
    if (!rst_n)            half <= 1'b0;
    else if (ovf && !dbl)  half <= ~half;
  end

  assign os_tick = ovf && (dbl || half);
endmodule

// File: rtl/u2_tx.sv
module u2_tx #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          load,
  input  logic [DW-1:0] data,
  input  logic          nine_en,
  input  logic          nine_bit,
  output logic          txd,
  output logic          busy,
  output logic          done
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OSR);
  localparam int NW = $clog2(FW + 1);

  logic [FW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [NW-1:0] bitn;
  logic [NW-1:0] last;
  logic          live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '1;
      cnt  <= '0;
      bitn <= '0;
      last <= '0;
      busy <= 1'b0;
      live <= 1'b0;
      txd  <= 1'b1;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load && !busy) begin
        busy <= 1'b1;
        live <= 1'b0;
        sh   <= {1'b1, (nine_en ? nine_bit : 1'b1), data, 1'b0};
        last <= nine_en ? NW'(FW-1) : NW'(FW-2);
        bitn <= '0;
        cnt  <= '0;
      end else if (busy && os_tick) begin
        if (!live) begin
          live <= 1'b1;
          txd  <= sh[0];
        end else if (cnt == CW'(OSR-1)) begin
          cnt <= '0;
          if (bitn == last) begin
            busy <= 1'b0;
            live <= 1'b0;
            done <= 1'b1;
            txd  <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
            sh   <= {1'b1, sh[FW-1:1]};
            txd  <= sh[1];
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/u2_rx.sv
module u2_rx #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rxd_raw,
  input  logic          en,
  input  logic          nine_en,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          ninth,
  output logic          stop_ok
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam int NW  = $clog2(DW + 2);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_st_e;

  rx_st_e        st;
  logic          s1, s2, v1, v2;
  logic [CW-1:0] cnt;
  logic [DW:0]   sh;
  logic [NW-1:0] bitn;
  logic          vote;

  assign vote = (v1 & v2) | (v1 & s2) | (v2 & s2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      s1      <= 1'b1;
      s2      <= 1'b1;
      v1      <= 1'b1;
      v2      <= 1'b1;
      cnt     <= '0;
      sh      <= '0;
      bitn    <= '0;
      valid   <= 1'b0;
      data    <= '0;
      ninth   <= 1'b0;
      stop_ok <= 1'b1;
    end else begin
      s1    <= rxd_raw;
      s2    <= s1;
      valid <= 1'b0;
      if (os_tick) begin
        if (st == RX_IDLE) begin
          if (en && !s2) begin
            st  <= RX_START;
            cnt <= '0;
          end
        end else begin
          cnt <= (cnt == CW'(OSR-1)) ? '0 : cnt + 1'b1;
          if (cnt == CW'(MID-1)) v1 <= s2;
          if (cnt == CW'(MID))   v2 <= s2;
          if (cnt == CW'(MID+1)) begin
            case (st)
              RX_START: if (vote) st <= RX_IDLE;
              RX_BITS:  sh <= {vote, sh[DW:1]};
              RX_STOP: begin
                valid   <= 1'b1;
                stop_ok <= vote;
                data    <= nine_en ? sh[DW-1:0] : sh[DW:1];
                ninth   <= nine_en & sh[DW];
                st      <= RX_IDLE;
              end
              default: ;
            endcase
          end
          if (cnt == CW'(OSR-1)) begin
            if (st == RX_START) begin
              st   <= RX_BITS;
              bitn <= '0;
            end else if (st == RX_BITS) begin
              bitn <= bitn + 1'b1;
              if (bitn == (nine_en ? NW'(DW) : NW'(DW-1))) st <= RX_STOP;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/u2_port.sv
module u2_port
  import u2_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [DW-1:0]     sfr_wdata,
  input  logic              sfr_wr,
  input  logic              sfr_rd,
  output logic [DW-1:0]     sfr_rdata,
  input  logic              tmr1_ovf,
  input  logic              tmr2_ovf,
  output logic              txd,
  input  logic              rxd,
  output logic              irq
);
  logic rxf, txf, rx9, tx9, ren, mpe, mode9, fe;
  logic dbl, rxsrc, txsrc, feen, ien;
  logic [DW-1:0] rbuf, saddr, smask;

  logic [1:0] src_sel, os;
  logic tx_busy, tx_done, tx_load;
  logic rx_valid, rx_ninth, rx_stop, rx_accept, addr_ok;
  logic [DW-1:0] rx_data;
  logic [7:0] ctrl_view, aux_view;

  // index 0 feeds the receiver, index 1 the transmitter
  assign src_sel = {txsrc, rxsrc};

  for (genvar g = 0; g < 2; g++) begin : g_rate
    u2_baud u_bd (
      .clk(clk), .rst_n(rst_n), .ovf_a(tmr1_ovf), .ovf_b(tmr2_ovf),
      .sel(src_sel[g]), .dbl(dbl), .os_tick(os[g])
    );
  end

  assign tx_load = sfr_wr && (sfr_addr == RA_DATA);

  u2_tx #(.DW(DW), .OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .os_tick(os[1]), .load(tx_load),
    .data(sfr_wdata), .nine_en(mode9), .nine_bit(tx9),
    .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  u2_rx #(.DW(DW), .OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os[0]), .rxd_raw(rxd),
    .en(ren), .nine_en(mode9), .valid(rx_valid), .data(rx_data),
    .ninth(rx_ninth), .stop_ok(rx_stop)
  );

  function automatic logic match_any(input logic [DW-1:0] d, own, msk);
    logic given, bcast;
    given = ((d ^ own) & msk) == '0;
    bcast = ((d ^ (own | msk)) & msk) == '0;
    return given | bcast;
  endfunction

  assign addr_ok   = match_any(rx_data, saddr, smask);
  assign rx_accept = rx_valid && (!mode9 || !mpe || (rx_ninth && addr_ok));

  assign ctrl_view = {(feen ? fe : mode9), 1'b0, mpe, ren, tx9, rx9, txf, rxf};
  assign aux_view  = {2'b00, mode9, ien, feen, txsrc, rxsrc, dbl};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {rxf, txf, rx9, tx9, ren, mpe, mode9, fe} <= '0;
      {dbl, rxsrc, txsrc, feen, ien}            <= '0;
      rbuf  <= '0;
      saddr <= '0;
      smask <= '0;
    end else begin
      if (sfr_wr) begin
        case (sfr_addr)
          RA_CTRL: begin
            rxf <= sfr_wdata[0];
            txf <= sfr_wdata[1];
            rx9 <= sfr_wdata[2];
            tx9 <= sfr_wdata[3];
            ren <= sfr_wdata[4];
            mpe <= sfr_wdata[5];
            if (feen) begin
              if (!sfr_wdata[7]) fe <= 1'b0;
            end else begin
              mode9 <= sfr_wdata[7];
            end
          end
          RA_AUX: begin
            dbl   <= sfr_wdata[0];
            rxsrc <= sfr_wdata[1];
            txsrc <= sfr_wdata[2];
            feen  <= sfr_wdata[3];
            ien   <= sfr_wdata[4];
            mode9 <= sfr_wdata[5];
          end
          RA_SADDR: saddr <= sfr_wdata;
          RA_SMASK: smask <= sfr_wdata;
          default: ;
        endcase
      end
      if (tx_done) txf <= 1'b1;
      if (rx_accept) begin
        rxf  <= 1'b1;
        rbuf <= rx_data;
        rx9  <= rx_ninth;
      end
      if (rx_valid && feen && !rx_stop) fe <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sfr_rdata <= '0;
    end else if (sfr_rd) begin
      case (sfr_addr)
        RA_DATA:  sfr_rdata <= rbuf;
        RA_CTRL:  sfr_rdata <= ctrl_view;
        RA_AUX:   sfr_rdata <= aux_view;
        RA_SADDR: sfr_rdata <= saddr;
        RA_SMASK: sfr_rdata <= smask;
        default:  sfr_rdata <= '0;
      endcase
    end
  end

  assign irq = ien & (rxf | txf);
endmodule

// File: rtl/u2_port_chk.sv
module u2_port_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic tx_busy,
  input logic tx_done,
  input logic txf,
  input logic rx_valid,
  input logic rx_ninth,
  input logic rx_stop,
  input logic mode9,
  input logic mpe,
  input logic rxf,
  input logic fe,
  input logic sfr_wr
);
  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  // R2
  start_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> tx_busy);

  // R4
  txf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> txf);

  // R3
  rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !mode9 && !sfr_wr) |=> rxf);

  // R6
  mpe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mode9 && mpe && !rx_ninth && !rxf && !sfr_wr) |=> !rxf);

  // R9
  fe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe) |-> ($past(rx_valid) && !$past(rx_stop)));
endmodule

bind u2_port u2_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy), .tx_done(tx_done),
  .txf(txf), .rx_valid(rx_valid), .rx_ninth(rx_ninth), .rx_stop(rx_stop),
  .mode9(mode9), .mpe(mpe), .rxf(rxf), .fe(fe), .sfr_wr(sfr_wr)
);

// File: tb/sim_u2_port.sv
`timescale 1ns/100ps
module sim_u2_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sfr_addr = '0;
  logic [7:0] sfr_wdata = '0;
  logic sfr_wr = 1'b0, sfr_rd = 1'b0;
  logic [7:0] sfr_rdata;
  logic tmr1_ovf, tmr2_ovf, txd, rxd, irq;
  logic force_low = 1'b0;
  logic tx_active = 1'b0;
  int c1 = 0, c2 = 0;
  int n_chk = 0, n_err = 0, line_bad = 0;
  bit finished = 0;
  logic [7:0] cfg_ctrl;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    c1 <= (c1 == 2) ? 0 : c1 + 1;
    c2 <= (c2 == 4) ? 0 : c2 + 1;
  end
  assign tmr1_ovf = rst_n && (c1 == 0);
  assign tmr2_ovf = rst_n && (c2 == 0);
  assign rxd = txd & ~force_low;

  u2_port u0 (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata),
    .tmr1_ovf(tmr1_ovf), .tmr2_ovf(tmr2_ovf), .txd(txd), .rxd(rxd), .irq(irq)
  );

  // model of the line: with no frame in flight the transmit line stays high
  always @(negedge clk) begin
    if (rst_n && !tx_active && txd !== 1'b1) line_bad++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_rd = 1'b1;
    @(negedge clk);
    sfr_rd = 1'b0;
    d = sfr_rdata;
  endtask

  task automatic wait_txf(output logic [7:0] c);
    c = '0;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd1, c);
      if (c[1]) break;
    end
    chk(c[1] === 1'b1, "R4 transmit flag", c[1], 1);
    tx_active = 1'b0;
  endtask

  // send one byte over the loop; width = start-bit length in cycles
  task automatic xfer(input logic [7:0] d, input bit force_stop,
                      output logic [7:0] c, output logic [7:0] r, output int width);
    tx_active = 1'b1;
    wr(3'd0, d);
    @(negedge txd);
    @(negedge clk);
    width = 0;
    while (txd == 1'b0) begin
      width++;
      @(negedge clk);
    end
    if (force_stop) begin
      repeat (391) @(posedge clk);
      force_low = 1'b1;
      repeat (30) @(posedge clk);
      force_low = 1'b0;
    end
    wait_txf(c);
    rd(3'd1, c);
    rd(3'd0, r);
  endtask

  task automatic clr();
    wr(3'd1, cfg_ctrl);
  endtask

  function automatic bit exp_take(input logic [7:0] d, input logic ninth,
                                  input logic [7:0] own, input logic [7:0] msk);
    bit given, bcast;
    given = 1; bcast = 1;
    for (int b = 0; b < 8; b++) begin
      if (msk[b] && d[b] != own[b]) given = 0;
      if (msk[b] && d[b] != 1'b1) bcast = 0;
    end
    return ninth && (given || bcast);
  endfunction

  task automatic addr_case(input logic [7:0] own, input logic [7:0] msk,
                           input logic [7:0] d, input logic ninth, input string req);
    logic [7:0] c, r;
    int w;
    bit e;
    cfg_ctrl = ninth ? 8'hB8 : 8'hB0;
    wr(3'd1, cfg_ctrl);
    wr(3'd3, own);
    wr(3'd4, msk);
    xfer(d, 1'b0, c, r, w);
    e = exp_take(d, ninth, own, msk);
    chk(c[0] == e, req, c[0], e);
    if (e) chk(r == d, req, r, d);
    clr();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] c, r;
    int w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd1, c); chk(c == 8'h00, "R1 control reset", c, 0);
    rd(3'd2, c); chk(c == 8'h00, "R1 aux reset", c, 0);
    chk(txd == 1'b1, "R1 line idle", txd, 1);
    chk(irq == 1'b0, "R1 irq low", irq, 0);
    rd(3'd6, c); chk(c == 8'h00, "R11 unused address", c, 0);

    // 8-bit mode, first timer, double rate
    wr(3'd2, 8'h01);
    cfg_ctrl = 8'h10; wr(3'd1, cfg_ctrl);
    xfer(8'hA5, 1'b0, c, r, w);
    chk(c[0] == 1'b1, "R3 receive flag", c[0], 1);
    chk(r == 8'hA5, "R3 R11 byte A5", r, 8'hA5);
    chk(c[2] == 1'b0, "R3 ninth clear in 8-bit", c[2], 0);
    chk(w == 48, "R5 width t1 double", w, 48);
    chk(irq == 1'b0, "R10 irq gated off", irq, 0);
    clr();
    rd(3'd1, c); chk(c[1:0] == 2'b00, "R12 flags cleared", c[1:0], 0);

    xfer(8'h3C, 1'b0, c, r, w);
    chk(r == 8'h3C, "R3 byte 3C", r, 8'h3C);
    clr();

    // R2 write during frame is ignored
    tx_active = 1'b1;
    wr(3'd0, 8'h81);
    wr(3'd0, 8'h7E);
    wait_txf(c);
    rd(3'd0, r);
    chk(r == 8'h81, "R2 busy write ignored", r, 8'h81);
    clr();

    // R10 interrupt
    wr(3'd2, 8'h11);
    xfer(8'h96, 1'b0, c, r, w);
    chk(irq == 1'b1, "R10 irq raised", irq, 1);
    clr();
    @(negedge clk);
    chk(irq == 1'b0, "R10 irq dropped", irq, 0);

    // R5 rate selection
    wr(3'd2, 8'h00);
    xfer(8'h55, 1'b0, c, r, w);
    chk(w == 96, "R5 width t1 halved", w, 96);
    chk(r == 8'h55, "R5 byte halved", r, 8'h55);
    clr();
    wr(3'd2, 8'h06);
    xfer(8'hC7, 1'b0, c, r, w);
    chk(w == 160, "R5 width t2 halved", w, 160);
    chk(r == 8'hC7, "R5 byte t2", r, 8'hC7);
    clr();
    wr(3'd2, 8'h07);
    xfer(8'h19, 1'b0, c, r, w);
    chk(w == 80, "R5 width t2 double", w, 80);
    clr();
    wr(3'd2, 8'h01);

    // R3 receive disabled
    cfg_ctrl = 8'h00; wr(3'd1, cfg_ctrl);
    xfer(8'h11, 1'b0, c, r, w);
    chk(c[0] == 1'b0, "R3 receive disabled", c[0], 0);
    clr();

    // R3 short glitch rejected
    cfg_ctrl = 8'h10; wr(3'd1, cfg_ctrl);
    force_low = 1'b1;
    repeat (10) @(posedge clk);
    force_low = 1'b0;
    repeat (300) @(posedge clk);
    rd(3'd1, c);
    chk(c[0] == 1'b0, "R3 glitch rejected", c[0], 0);

    // 9-bit mode, filtering off
    cfg_ctrl = 8'h98; wr(3'd1, cfg_ctrl);
    xfer(8'h5A, 1'b0, c, r, w);
    chk(c[2] == 1'b1 && r == 8'h5A, "R2 R3 ninth one", {c[2], r}, 9'h15A);
    clr();
    cfg_ctrl = 8'h90; wr(3'd1, cfg_ctrl);
    xfer(8'hC3, 1'b0, c, r, w);
    chk(c[2] == 1'b0 && r == 8'hC3, "R2 R3 ninth zero", {c[2], r}, 9'h0C3);
    clr();

    // address filtering
    addr_case(8'h42, 8'hFF, 8'h42, 1'b1, "R7 full mask hit");
    addr_case(8'h42, 8'hFF, 8'h43, 1'b1, "R7 full mask miss");
    addr_case(8'h42, 8'hFF, 8'hFF, 1'b1, "R8 broadcast full");
    addr_case(8'h42, 8'hFF, 8'h42, 1'b0, "R6 data frame dropped");
    addr_case(8'h30, 8'hF0, 8'h37, 1'b1, "R7 upper mask hit");
    addr_case(8'h30, 8'hF0, 8'hF5, 1'b1, "R8 upper broadcast");
    addr_case(8'h30, 8'hF0, 8'h25, 1'b1, "R7 upper mask miss");
    addr_case(8'h05, 8'h0F, 8'hA5, 1'b1, "R7 lower mask hit");
    addr_case(8'h05, 8'h0F, 8'hAF, 1'b1, "R8 lower broadcast");
    addr_case(8'h05, 8'h0F, 8'h06, 1'b1, "R7 lower mask miss");
    addr_case(8'h00, 8'h00, 8'h99, 1'b1, "R7 empty mask");

    // R9 framing check
    cfg_ctrl = 8'h10; wr(3'd1, cfg_ctrl);
    wr(3'd2, 8'h01);
    xfer(8'h33, 1'b1, c, r, w);
    chk(c[7] == 1'b0 && c[0] == 1'b1, "R9 check off", {c[7], c[0]}, 1);
    clr();
    wr(3'd2, 8'h09);
    xfer(8'h44, 1'b0, c, r, w);
    chk(c[7] == 1'b0, "R9 good stop", c[7], 0);
    clr();
    xfer(8'h33, 1'b1, c, r, w);
    chk(c[7] == 1'b1, "R9 flag set", c[7], 1);
    wr(3'd1, 8'h90);
    rd(3'd1, c);
    chk(c[7] == 1'b1, "R9 write one keeps", c[7], 1);
    rd(3'd2, c);
    chk(c[5] == 1'b0, "R9 mode bit untouched", c[5], 0);
    clr();
    rd(3'd1, c);
    chk(c[7] == 1'b0, "R9 flag cleared", c[7], 0);
    wr(3'd2, 8'h29);
    rd(3'd2, c);
    chk(c[5] == 1'b1, "R9 mode alias", c[5], 1);
    rd(3'd1, c);
    chk(c[7] == 1'b0, "R9 top bit shows flag", c[7], 0);

    chk(line_bad == 0, "R1 R2 idle line model", line_bad, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule